// File: doc/BRIEF.md
# SHA Message Padding Block Former

This block sits in front of a SHA-1 or SHA-256 compression core. It collects a message one byte at a time, groups the bytes into 64-byte blocks and passes each block to the core as sixteen 32-bit words. When the message is complete, it appends the standard closing padding: a single 0x80 marker byte, zero fill, and the message length in bits.

Input bytes arrive on a valid/ready handshake. A one-cycle `finish` request ends the message. A full block is not sent when its 64th byte arrives. It stays buffered until either another byte is presented or the message is finished. As a result, a message whose length is a multiple of 64 bytes still has its last data block available for the closing sequence.

The closing sequence produces one block when 55 or fewer bytes are buffered and two blocks otherwise. A `done` pulse marks the end of the closing sequence, and the block is then ready for the next message.

Top module: `sha_pad_gen`

## Requirements
- R1: After reset, and after any reset during a message, `in_ready` is 1, `out_valid` is 0 and `done` is 0. The byte total restarts from zero.
- R2: Bytes are packed big-endian. Byte k of a block appears in word k/4, and byte k%4 = 0 occupies bits [31:24].
- R3: A block of 64 buffered bytes is held and not emitted while no further byte and no `finish` arrives. When a 65th byte is presented, the held block is emitted unchanged before that byte is taken.
- R4: `in_ready` is 0 in every cycle in which `out_valid` is 1.
- R5: With 1 to 55 bytes buffered at `finish`, exactly one closing block is emitted. It contains the buffered bytes, then 0x80 at the next byte position, then zeros. Its word 15 equals 8 times the byte total, with the most significant byte first.
- R6: With 56 to 63 bytes buffered at `finish`, two closing blocks are emitted. The first holds the bytes, then 0x80, then zeros, and carries no length. The second is all zero except word 15, which holds the bit length.
- R7: With exactly 64 bytes buffered at `finish`, that block is emitted unchanged. It is followed by a block whose word 0 is 0x80000000 and whose word 15 is the bit length, with all other words zero.
- R8: A `finish` with no bytes received emits one block with word 0 = 0x80000000 and all other words zero, so the length word is zero.
- R9: The length counts every byte of the message, including bytes already sent in full blocks during the update phase.
- R10: While `out_valid` is 1 and `out_ready` is 0, `out_word` and `out_valid` hold their values.
- R11: `done` is a single-cycle pulse in the cycle after the last word of the last closing block is accepted. A following message starts with a byte total of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Message byte is valid |
| in_byte | input | 8 | Message byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| finish | input | 1 | End of message; taken when no block is being emitted |
| out_valid | output | 1 | `out_word` holds a block word |
| out_word | output | 32 | Block word, words 0..15 in order |
| out_ready | input | 1 | Core accepts the word |
| done | output | 1 | Pulse after the final padded word is accepted |

## Verification
`in_ready` and `out_valid` are decoded from registered state, so they change only one edge after the handshake that causes the change. The first closing word is valid in the cycle after `finish` is taken, and `done` rises one edge after the last word is accepted. The bench drives its inputs and samples the outputs at the falling edge. It records each handshake at the sample that precedes the edge that completes it, and then expects `done` at the very next falling edge. Each expected word is built from the standard padding rule for the message length being tested, and the bench compares words in order as they are accepted, under both continuous and stalled `out_ready`.

// File: rtl/sha_pad_pkg.sv
package sha_pad_pkg;
  typedef enum logic [1:0] {
    ST_FILL = 2'd0,
    ST_SEND = 2'd1,
    ST_CL1  = 2'd2,
    ST_CL2  = 2'd3
  } pad_state_t;
endpackage

// File: rtl/sha_pad_buf.sv
// Block buffer: one narrow memory per byte lane, written one byte at a time,
// read one full word at a time.
module sha_pad_buf #(
  parameter int WORD_BYTES = 4,
  parameter int BLK_WORDS  = 16,
  localparam int WORD_W = 8 * WORD_BYTES,
  localparam int IDX_W  = $clog2(BLK_WORDS),
  localparam int LANE_W = $clog2(WORD_BYTES)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_word,
  input  logic [LANE_W-1:0] wr_lane,
  input  logic [7:0]        wr_byte,
  input  logic [IDX_W-1:0]  rd_word,
  output logic [WORD_W-1:0] rd_data
);
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    logic [7:0] lane_mem [BLK_WORDS];

    always_ff @(posedge clk) begin
      if (wr_en && wr_lane == LANE_W'(g)) begin
        lane_mem[wr_word] <= wr_byte;
      end
    end

    // Lane 0 carries the first byte of the word and sits in the top bits.
    assign rd_data[WORD_W-1-8*g -: 8] = lane_mem[rd_word];
  end
endmodule

// File: rtl/sha_pad_former.sv
// Combinational word former: applies marker, zero fill and length word.
module sha_pad_former #(
  parameter int WORD_BYTES = 4,
  parameter int BLK_WORDS  = 16,
  localparam int WORD_W    = 8 * WORD_BYTES,
  localparam int IDX_W     = $clog2(BLK_WORDS),
  localparam int BLK_BYTES = WORD_BYTES * BLK_WORDS,
  localparam int CNT_W     = $clog2(BLK_BYTES + 1)
) (
  input  logic [WORD_W-1:0] raw,
  input  logic [IDX_W-1:0]  widx,
  input  logic [CNT_W-1:0]  fill,
  input  logic              close1,
  input  logic              close2,
  input  logic [WORD_W-1:0] bitlen,
  output logic [WORD_W-1:0] word
);
  // A single closing block must leave room for the marker and the
  // two-word length area at its end.
  localparam int ONE_BLK_MAX = BLK_BYTES - 1 - 2 * WORD_BYTES;

  logic [WORD_W-1:0] body;
  logic              is_last;
  logic              put_len;

  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    logic [CNT_W-1:0] pos;
    logic [7:0]       lane_b;

    assign pos = CNT_W'(widx) * CNT_W'(WORD_BYTES) + CNT_W'(g);

    always_comb begin
      if (close2) begin
        lane_b = (widx == '0 && g == 0 && fill == CNT_W'(BLK_BYTES)) ? 8'h80 : 8'h00;
      end else if (pos < fill) begin
        lane_b = raw[WORD_W-1-8*g -: 8];
      end else if (close1 && pos == fill) begin
        lane_b = 8'h80;
      end else begin
        lane_b = 8'h00;
      end
    end

    assign body[WORD_W-1-8*g -: 8] = lane_b;
  end

  assign is_last = (widx == IDX_W'(BLK_WORDS - 1));
  assign put_len = is_last && (close2 || (close1 && fill <= CNT_W'(ONE_BLK_MAX)));
  assign word    = put_len ? bitlen : body;
endmodule

// File: rtl/sha_pad_ctrl.sv
// Sequencer: fill counter, word index, byte total and block selection.
module sha_pad_ctrl
  import sha_pad_pkg::*;
#(
  parameter int WORD_BYTES = 4,
  parameter int BLK_WORDS  = 16,
  parameter int LEN_W      = 32,
  localparam int IDX_W     = $clog2(BLK_WORDS),
  localparam int LANE_W    = $clog2(WORD_BYTES),
  localparam int BLK_BYTES = WORD_BYTES * BLK_WORDS,
  localparam int CNT_W     = $clog2(BLK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              finish,
  input  logic              out_ready,
  output logic              in_ready,
  output logic              out_valid,
  output logic              done,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_word,
  output logic [LANE_W-1:0] wr_lane,
  output logic [IDX_W-1:0]  widx,
  output logic [CNT_W-1:0]  fill,
  output logic              close1,
  output logic              close2,
  output logic [LEN_W-1:0]  total
);
  localparam int ONE_BLK_MAX = BLK_BYTES - 1 - 2 * WORD_BYTES;

  pad_state_t state;
  logic       shift;
  logic       last;

  assign in_ready  = (state == ST_FILL) && (fill < CNT_W'(BLK_BYTES));
  assign out_valid = (state != ST_FILL);
  assign close1    = (state == ST_CL1);
  assign close2    = (state == ST_CL2);
  assign wr_en     = in_valid && in_ready;
  assign wr_word   = IDX_W'(fill >> LANE_W);
  assign wr_lane   = LANE_W'(fill);
  assign shift     = out_valid && out_ready;
  assign last      = shift && (widx == IDX_W'(BLK_WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_FILL;
      fill  <= '0;
      widx  <= '0;
      total <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (shift) widx <= widx + 1'b1;
      unique case (state)
        ST_FILL: begin
          if (wr_en) begin
            fill  <= fill + 1'b1;
            total <= total + 1'b1;
          end
          if (finish) begin
            state <= ST_CL1;
          end else if (in_valid && fill == CNT_W'(BLK_BYTES)) begin
            state <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (last) begin
            state <= ST_FILL;
            fill  <= '0;
          end
        end
        ST_CL1: begin
          if (last) begin
            if (fill > CNT_W'(ONE_BLK_MAX)) begin
              state <= ST_CL2;
            end else begin
              state <= ST_FILL;
              fill  <= '0;
              total <= '0;
              done  <= 1'b1;
            end
          end
        end
        ST_CL2: begin
          if (last) begin
            state <= ST_FILL;
            fill  <= '0;
            total <= '0;
            done  <= 1'b1;
          end
        end
        default: state <= ST_FILL;
      endcase
    end
  end
endmodule

// File: rtl/sha_pad_gen.sv
module sha_pad_gen #(
  parameter int WORD_BYTES = 4,
  parameter int BLK_WORDS  = 16,
  parameter int LEN_W      = 32,
  localparam int WORD_W    = 8 * WORD_BYTES,
  localparam int IDX_W     = $clog2(BLK_WORDS),
  localparam int LANE_W    = $clog2(WORD_BYTES),
  localparam int BLK_BYTES = WORD_BYTES * BLK_WORDS,
  localparam int CNT_W     = $clog2(BLK_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  input  logic              finish,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  input  logic              out_ready,
  output logic              done
);
  logic              wr_en;
  logic [IDX_W-1:0]  wr_word;
  logic [LANE_W-1:0] wr_lane;
  logic [IDX_W-1:0]  widx;
  logic [CNT_W-1:0]  fill;
  logic              close1;
  logic              close2;
  logic [LEN_W-1:0]  total;
  logic [WORD_W-1:0] raw;
  logic [WORD_W-1:0] bitlen;

  // Bit length: the byte total times eight, truncated to one word.
  assign bitlen = WORD_W'({total, 3'b000});

  sha_pad_ctrl #(
    .WORD_BYTES(WORD_BYTES), .BLK_WORDS(BLK_WORDS), .LEN_W(LEN_W)
  ) i_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .finish(finish),
    .out_ready(out_ready), .in_ready(in_ready), .out_valid(out_valid),
    .done(done), .wr_en(wr_en), .wr_word(wr_word), .wr_lane(wr_lane),
    .widx(widx), .fill(fill), .close1(close1), .close2(close2), .total(total)
  );

  sha_pad_buf #(
    .WORD_BYTES(WORD_BYTES), .BLK_WORDS(BLK_WORDS)
  ) i_buf (
    .clk(clk), .wr_en(wr_en), .wr_word(wr_word), .wr_lane(wr_lane),
    .wr_byte(in_byte), .rd_word(widx), .rd_data(raw)
  );

  sha_pad_former #(
    .WORD_BYTES(WORD_BYTES), .BLK_WORDS(BLK_WORDS)
  ) i_former (
    .raw(raw), .widx(widx), .fill(fill), .close1(close1), .close2(close2),
    .bitlen(bitlen), .word(out_word)
  );
endmodule

// File: rtl/sha_pad_chk.sv
module sha_pad_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_word,
  input logic              done
);
  p_busy_blocks_input_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  p_word_held_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));

  p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_after_accept_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(out_valid && out_ready));

  p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
    done |-> (!out_valid && in_ready));
endmodule

bind sha_pad_gen sha_pad_chk #(.WORD_W(WORD_W)) i_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_word(out_word), .done(done)
);

// File: tb/test_sha_pad_gen.sv
`timescale 1ns/1ps
module test_sha_pad_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_ready;
  logic        finish = 1'b0;
  logic        out_valid;
  logic [31:0] out_word;
  logic        out_ready = 1'b0;
  logic        done;

  int errors = 0;
  int checks = 0;
  bit ended  = 0;

  always #2.5 clk = ~clk;

  sha_pad_gen i_sha_pad_gen (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .finish(finish), .out_valid(out_valid),
    .out_word(out_word), .out_ready(out_ready), .done(done)
  );

  // Vector table: message length, data seed, stall pattern, expected word count.
  localparam int NV = 10;
  localparam int VLEN   [NV] = '{0, 3, 55, 56, 63, 64, 70, 119, 120, 128};
  localparam int VSEED  [NV] = '{1, 2, 3, 4, 5, 6, 7, 8, 9, 10};
  localparam bit VSTALL [NV] = '{0, 1, 0, 1, 0, 1, 0, 1, 0, 1};
  localparam int VWORDS [NV] = '{16, 16, 16, 32, 32, 32, 32, 32, 48, 48};

  function automatic logic [7:0] msg_byte(int k, int seed);
    return 8'((k * 13 + seed * 29 + 1) & 255);
  endfunction

  // Standard padding rule, computed independently of the design.
  function automatic logic [7:0] exp_byte(int p, int nb, int seed);
    int tot;
    logic [31:0] bl;
    tot = 64 * ((nb + 8) / 64 + 1);
    bl  = 32'(nb * 8);
    if (p < nb) return msg_byte(p, seed);
    if (p == nb) return 8'h80;
    if (p >= tot - 4) return bl[31 - 8 * (p - (tot - 4)) -: 8];
    return 8'h00;
  endfunction

  function automatic logic [31:0] exp_word(int wi, int nb, int seed);
    return {exp_byte(4*wi, nb, seed), exp_byte(4*wi+1, nb, seed),
            exp_byte(4*wi+2, nb, seed), exp_byte(4*wi+3, nb, seed)};
  endfunction

  function automatic string len_tag(int nb);
    if (nb == 0) return "R8";
    if (nb > 64) return "R9";
    if (nb == 64) return "R7";
    if (nb >= 56) return "R6";
    return "R5";
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One message: feed bytes, optional idle gap, finish, collect and compare words.
  task automatic run_msg(int nb, int seed, bit stall, int gap, int nwords);
    int bi = 0;
    int wi = 0;
    int cyc = 0;
    int g = gap;
    bit fin_sent = 0;
    bit busy_bad = 0;
    bit gap_bad = 0;
    bit held = 0;
    logic [31:0] held_w = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cyc > 4000) begin
        check(0, len_tag(nb), "message timeout", wi, nwords);
        break;
      end
      if (wi == nwords) begin
        check(done == 1'b1, "R11", "done after last word", done, 1);
        check(out_valid == 1'b0, len_tag(nb), "no extra block", out_valid, 0);
        break;
      end
      if (done) check(0, "R11", "early done", wi, nwords);
      if (held) begin
        check(out_valid && out_word == held_w, "R10", "word held under stall", out_word, held_w);
        held = 0;
      end
      if (out_valid && in_ready) busy_bad = 1;
      in_valid = (bi < nb);
      in_byte  = msg_byte(bi, seed);
      finish   = 1'b0;
      if (bi >= nb && !fin_sent) begin
        if (g > 0) begin
          if (out_valid) gap_bad = 1;
          g--;
        end else if (!out_valid) begin
          finish   = 1'b1;
          fin_sent = 1;
        end
      end
      out_ready = stall ? (cyc % 3 != 0) : 1'b1;
      if (in_valid && in_ready) bi++;
      if (out_valid && out_ready) begin
        if (wi < nwords) begin
          // R2: big-endian packing is part of every word comparison.
          check(out_word == exp_word(wi, nb, seed), len_tag(nb), $sformatf("len %0d word %0d", nb, wi),
                out_word, exp_word(wi, nb, seed));
        end
        wi++;
      end else if (out_valid) begin
        held   = 1;
        held_w = out_word;
      end
    end
    check(!busy_bad, "R4", "input ready while emitting", busy_bad, 0);
    if (gap > 0) check(!gap_bad, "R3", "full block emitted without trigger", gap_bad, 0);
    in_valid  = 1'b0;
    finish    = 1'b0;
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0 && done == 1'b0, "R1", "reset state",
          {in_ready, out_valid, done}, 3'b100);

    // Table walk; messages run back to back, so each length also checks the
    // byte total restart of R11.
    for (int v = 0; v < NV; v++) begin
      run_msg(VLEN[v], VSEED[v], VSTALL[v], 0, VWORDS[v]);
    end

    // R3: a full block is held through idle cycles until finish.
    run_msg(64, 21, 0, 12, 32);
    run_msg(128, 22, 1, 7, 48);

    // R1: reset in the middle of a message clears the byte total.
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_byte  = msg_byte(k, 3);
    end
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1 && out_valid == 1'b0 && done == 1'b0, "R1", "state after mid-message reset",
          {in_ready, out_valid, done}, 3'b100);
    run_msg(0, 30, 0, 0, 16);
    run_msg(5, 31, 1, 0, 16);

    if (!ended) begin
      ended = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!ended) begin
      ended = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule